// File: doc/BRIEF.md
# Flash Operation Status Bit Generator

This block produces the status word that a parallel NOR flash puts on its data pins while an internal program or erase is under way. A command decoder that sits in front of it has already recognised the bus-cycle unlock sequences. That decoder hands over one command event per cycle together with a target address and data. The array's current contents are also supplied as inputs, both the word at the program target and the word at the read address. Each cycle the block either passes array data through or builds a status word from a set of flag bits. It also drives a ready/busy flag.

Internally the block tracks the running operation. This covers a sector-erase acceptance window that collects more sectors and restarts its time-out on each one. It also covers an erase that can be suspended and resumed, a program nested inside a suspended erase, and a failure state. The failure state is reached when a program asks to raise a bit that already holds 0. Two toggle flip-flops advance on read strobes so that software can poll for completion.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, and whenever no operation runs, `ready` is 1 and `dq` equals `arr_data`.
- R2: Command codes on `cmd_op` with `cmd_valid` high are 0 program, 1 sector erase, 2 chip erase, 3 suspend, 4 resume and 5 reset. A program accepted while idle holds `ready` at 0 for exactly PROG_CYC cycles. During that time status bit 7 is the complement of bit 7 of the written data. The block then returns to array read.
- R3: The status word places its flags at bits 7, 6, 5, 3 and 2, and all other bits are 0. Bit 6 inverts after every cycle with `rd_stb` high while a program, erase window, erase, suspended program or failure is active. Without a strobe it holds.
- R4: A program whose data has a 1 where `cell_old` has a 0 never completes. Bit 5 reads 0 for its first PULSE_LIM busy cycles and reads 1 from the next cycle on.
- R5: After a failure, `ready` stays 0 and bit 5 stays 1 under every command except reset. Reset returns the block to array read.
- R6: A sector erase opens a window in which bit 3 and bit 7 read 0. Each further sector-erase command adds its sector, taken from the top log2(NSECT) address bits, and restarts the full WIN_CYC count. A reset in the window abandons the erase.
- R7: When the window expires, or at once on a chip erase, the erase runs for ERASE_CYC cycles with bit 3 at 1 and bit 7 at 0. Completion returns the block to array read.
- R8: While the erase runs, every command except suspend is ignored, including reset.
- R9: In suspend, `ready` is 1. A read inside a selected sector returns bit 7 at 1 with bit 6 frozen. A read in any other sector returns `arr_data`.
- R10: A program issued in suspend holds `ready` at 0 for PROG_CYC cycles and then returns to suspend. Resume continues the erase from the cycle count reached before suspend.
- R11: Bit 2 inverts on strobed reads inside selected sectors during the window, the erase and suspend. It holds on reads of unselected sectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | A command event is present this cycle |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | AW | Target address of the command |
| cmd_data | input | DW | Data to be programmed |
| cell_old | input | DW | Current array contents at the program target |
| rd_stb | input | 1 | A read of the device occurs this cycle |
| rd_addr | input | AW | Address of the read |
| arr_data | input | DW | Array contents at the read address |
| dq | output | DW | Array data or status word |
| ready | output | 1 | 1 when ready, 0 when busy |

## Verification
The hardest state to reach is a program nested inside a suspended erase whose sector set was built up across a restarted window. To reach it, the stimulus issues a second sector erase partway through the window and waits out the full restarted count. It strobes reads across selected and unselected sectors while the erase runs, then issues a reset that must be ignored. Only after that does it suspend, program and resume. A behavioural reference model advances alongside the design on every edge and is compared on every cycle, so the resumed erase must end on exactly the remaining cycle count.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [2:0] {
    M_READ, M_PROG, M_WIN, M_ERASE, M_SUSP, M_SPROG, M_FAIL
  } mode_t;

  typedef enum logic [2:0] {
    OP_PROG   = 3'd0,
    OP_SERASE = 3'd1,
    OP_CERASE = 3'd2,
    OP_SUSP   = 3'd3,
    OP_RESUME = 3'd4,
    OP_RESET  = 3'd5
  } op_t;

  // A program can only clear bits; any requested 1 over a stored 0 stalls it.
  function automatic logic raises_zero(input logic [31:0] wr, input logic [31:0] cur);
    return |(wr & ~cur);
  endfunction

  // Sector index is the top sb bits of an aw-bit address.
  function automatic int unsigned sector_of(input logic [31:0] addr, input int aw, input int sb);
    return int'(addr >> (aw - sb));
  endfunction

  // Modes in which the polling bit advances on each read.
  function automatic logic polls_busy(input mode_t m);
    return (m == M_PROG) || (m == M_WIN) || (m == M_ERASE) || (m == M_SPROG) || (m == M_FAIL);
  endfunction

  // Modes in which the sector-selective bit advances on selected reads.
  function automatic logic polls_sector(input mode_t m);
    return (m == M_WIN) || (m == M_ERASE) || (m == M_SUSP);
  endfunction

  function automatic logic [7:0] status_word(input logic b7, input logic b6, input logic b5,
                                             input logic b3, input logic b2);
    return {b7, b6, b5, 1'b0, b3, b2, 2'b00};
  endfunction
endpackage

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
  import fsg_pkg::*;
#(
  parameter int AW        = 12,
  parameter int DW        = 8,
  parameter int NSECT     = 4,
  parameter int WIN_CYC   = 40,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 60,
  parameter int PULSE_LIM = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [DW-1:0]    cmd_data,
  input  logic [DW-1:0]    cell_old,
  output mode_t            mode,
  output logic [NSECT-1:0] sect_mask,
  output logic             pdata_msb,
  output logic             ev_prog_done,
  output logic             ev_fail,
  output logic             ev_win_expire,
  output logic             ev_erase_done
);
  localparam int SB    = $clog2(NSECT);
  localparam int OPMAX = (PULSE_LIM > WIN_CYC) ? PULSE_LIM : WIN_CYC;
  localparam int CW    = $clog2(OPMAX + 1);
  localparam int ECW   = $clog2(ERASE_CYC + 1);

  mode_t           mode_q, mode_d;
  logic [CW-1:0]   op_cnt;
  logic [ECW-1:0]  ers_cnt;
  logic            stall_q;
  logic [SB-1:0]   cmd_sect;
  logic            hit_prog, hit_se, hit_ce, hit_susp, hit_res, hit_rst;
  logic            prog_run, accept_prog, win_restart;

  assign cmd_sect  = SB'(sector_of(32'(cmd_addr), AW, SB));
  assign hit_prog  = cmd_valid && (cmd_op == OP_PROG);
  assign hit_se    = cmd_valid && (cmd_op == OP_SERASE);
  assign hit_ce    = cmd_valid && (cmd_op == OP_CERASE);
  assign hit_susp  = cmd_valid && (cmd_op == OP_SUSP);
  assign hit_res   = cmd_valid && (cmd_op == OP_RESUME);
  assign hit_rst   = cmd_valid && (cmd_op == OP_RESET);

  assign prog_run      = (mode_q == M_PROG) || (mode_q == M_SPROG);
  assign ev_prog_done  = prog_run && !stall_q && (op_cnt == CW'(PROG_CYC - 1));
  assign ev_fail       = prog_run && stall_q && (op_cnt == CW'(PULSE_LIM - 1));
  assign win_restart   = (mode_q == M_WIN) && hit_se && !hit_rst;
  assign ev_win_expire = (mode_q == M_WIN) && !hit_rst && !hit_se && (op_cnt == CW'(WIN_CYC - 1));
  assign ev_erase_done = (mode_q == M_ERASE) && (ers_cnt == ECW'(ERASE_CYC - 1));
  assign accept_prog   = hit_prog && ((mode_q == M_READ) || (mode_q == M_SUSP));

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      M_READ:  if (hit_prog) mode_d = M_PROG;
               else if (hit_se) mode_d = M_WIN;
               else if (hit_ce) mode_d = M_ERASE;
      M_PROG:  if (ev_fail) mode_d = M_FAIL;
               else if (ev_prog_done) mode_d = M_READ;
      M_WIN:   if (hit_rst) mode_d = M_READ;
               else if (ev_win_expire) mode_d = M_ERASE;
      M_ERASE: if (ev_erase_done) mode_d = M_READ;
               else if (hit_susp) mode_d = M_SUSP;
      M_SUSP:  if (hit_prog) mode_d = M_SPROG;
               else if (hit_res) mode_d = M_ERASE;
      M_SPROG: if (ev_fail) mode_d = M_FAIL;
               else if (ev_prog_done) mode_d = M_SUSP;
      M_FAIL:  if (hit_rst) mode_d = M_READ;
      default: mode_d = M_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_READ;
      op_cnt    <= '0;
      ers_cnt   <= '0;
      stall_q   <= 1'b0;
      pdata_msb <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if ((mode_d != mode_q) || win_restart)
        op_cnt <= '0;
      else if (prog_run || (mode_q == M_WIN))
        op_cnt <= op_cnt + 1'b1;
      if ((mode_d == M_ERASE) && ((mode_q == M_READ) || (mode_q == M_WIN)))
        ers_cnt <= '0;
      else if ((mode_q == M_ERASE) && !ev_erase_done)
        ers_cnt <= ers_cnt + 1'b1;
      if (accept_prog) begin
        stall_q   <= raises_zero(32'(cmd_data), 32'(cell_old));
        pdata_msb <= cmd_data[7];
      end
    end
  end

  // One flop per sector: set when the sector is named, cleared on return to read.
  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sect_mask[s] <= 1'b0;
      else if (mode_d == M_READ)
        sect_mask[s] <= 1'b0;
      else if ((mode_q == M_READ) && hit_ce)
        sect_mask[s] <= 1'b1;
      else if (((mode_q == M_READ) && hit_se) || win_restart)
        sect_mask[s] <= sect_mask[s] | (cmd_sect == SB'(s));
    end
  end

  assign mode = mode_q;
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle
  import fsg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_stb,
  input  mode_t mode,
  input  logic  rd_sel,
  output logic  tog6,
  output logic  tog2
);
  logic adv6, adv2;
  assign adv6 = rd_stb && polls_busy(mode);
  assign adv2 = rd_stb && rd_sel && polls_sector(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog6 <= 1'b0;
      tog2 <= 1'b0;
    end else begin
      if (adv6) tog6 <= ~tog6;
      if (adv2) tog2 <= ~tog2;
    end
  end
endmodule

// File: rtl/fsg_outmux.sv
module fsg_outmux
  import fsg_pkg::*;
#(
  parameter int DW = 8
) (
  input  mode_t         mode,
  input  logic          tog6,
  input  logic          tog2,
  input  logic          rd_sel,
  input  logic          pdata_msb,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] dq,
  output logic          ready
);
  always_comb begin
    dq    = arr_data;
    ready = 1'b1;
    unique case (mode)
      M_READ: ;
      M_PROG, M_SPROG: begin
        dq    = DW'(status_word(!pdata_msb, tog6, 1'b0, 1'b0, tog2));
        ready = 1'b0;
      end
      M_WIN: begin
        dq    = DW'(status_word(1'b0, tog6, 1'b0, 1'b0, tog2));
        ready = 1'b0;
      end
      M_ERASE: begin
        dq    = DW'(status_word(1'b0, tog6, 1'b0, 1'b1, tog2));
        ready = 1'b0;
      end
      M_SUSP: if (rd_sel) dq = DW'(status_word(1'b1, tog6, 1'b0, 1'b0, tog2));
      M_FAIL: begin
        dq    = DW'(status_word(!pdata_msb, tog6, 1'b1, 1'b0, tog2));
        ready = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import fsg_pkg::*;
#(
  parameter int AW        = 12,
  parameter int DW        = 8,
  parameter int NSECT     = 4,
  parameter int WIN_CYC   = 40,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 60,
  parameter int PULSE_LIM = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic [DW-1:0] cell_old,
  input  logic          rd_stb,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] dq,
  output logic          ready
);
  localparam int SB = $clog2(NSECT);

  mode_t            mode;
  logic [NSECT-1:0] sect_mask;
  logic             pdata_msb, tog6, tog2, rd_sel;
  logic             ev_prog_done, ev_fail, ev_win_expire, ev_erase_done;
  logic [SB-1:0]    rd_sect;

  assign rd_sect = SB'(sector_of(32'(rd_addr), AW, SB));
  assign rd_sel  = sect_mask[rd_sect];

  fsg_ctrl #(
    .AW(AW), .DW(DW), .NSECT(NSECT), .WIN_CYC(WIN_CYC),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .PULSE_LIM(PULSE_LIM)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cell_old(cell_old),
    .mode(mode), .sect_mask(sect_mask), .pdata_msb(pdata_msb),
    .ev_prog_done(ev_prog_done), .ev_fail(ev_fail),
    .ev_win_expire(ev_win_expire), .ev_erase_done(ev_erase_done)
  );

  fsg_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .mode(mode),
    .rd_sel(rd_sel), .tog6(tog6), .tog2(tog2)
  );

  fsg_outmux #(.DW(DW)) u_mux (
    .mode(mode), .tog6(tog6), .tog2(tog2), .rd_sel(rd_sel),
    .pdata_msb(pdata_msb), .arr_data(arr_data), .dq(dq), .ready(ready)
  );
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker
  import fsg_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic          rd_stb,
  input logic [DW-1:0] dq,
  input logic          ready,
  input mode_t         mode,
  input logic          tog6,
  input logic          pdata_msb,
  input logic          ev_erase_done
);
  logic is_rst, is_susp;
  assign is_rst  = cmd_valid && (cmd_op == OP_RESET);
  assign is_susp = cmd_valid && (cmd_op == OP_SUSP);

  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && dq[5] && !is_rst) |=> (!ready && dq[5])); // R5
  AST_TOG6_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(tog6)); // R3
  AST_ERASE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_ERASE) && !ev_erase_done && !is_susp) |=> (mode == M_ERASE)); // R8
  AST_SUSP_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SUSP) |-> ready); // R9
  AST_WIN_DQ3_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_WIN) |-> (!dq[3] && !dq[7] && !ready)); // R6
  AST_PROG_DQ7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PROG) |-> (dq[7] == !pdata_msb)); // R2
endmodule

bind flash_status_gen fsg_checker #(.DW(DW)) u_fsg_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .rd_stb(rd_stb), .dq(dq), .ready(ready), .mode(mode), .tog6(tog6),
  .pdata_msb(pdata_msb), .ev_erase_done(ev_erase_done)
);

// File: tb/flash_status_gen_bench.sv
module flash_status_gen_bench;
  localparam int PC = 8, WC = 40, EC = 60, PL = 24;
  localparam int MR = 0, MP = 1, MW = 2, ME = 3, MS = 4, MSP = 5, MF = 6;

  logic clk = 0, rst_n = 0;
  logic cmd_valid, rd_stb;
  logic [2:0] cmd_op;
  logic [11:0] cmd_addr, rd_addr;
  logic [7:0] cmd_data, cell_old, arr_data, dq;
  logic ready;
  int nchk = 0, nerr = 0;

  always #4 clk = ~clk;

  flash_status_gen u_flash_status_gen (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cell_old(cell_old),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .arr_data(arr_data),
    .dq(dq), .ready(ready)
  );

  // Behavioural reference
  int m, cnt, ecnt;
  bit stall, p7, t6, t2;
  bit [3:0] msk;

  function automatic int sec(input logic [11:0] a);
    return int'(a[11:10]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m = MR; cnt = 0; ecnt = 0; stall = 0; p7 = 0; t6 = 0; t2 = 0; msk = 0;
    end else begin
      bit hp, hs, hc, hu, hr, hx;
      hp = cmd_valid && cmd_op == 0; hs = cmd_valid && cmd_op == 1;
      hc = cmd_valid && cmd_op == 2; hu = cmd_valid && cmd_op == 3;
      hr = cmd_valid && cmd_op == 4; hx = cmd_valid && cmd_op == 5;
      if (rd_stb) begin
        if (m == MP || m == MW || m == ME || m == MSP || m == MF) t6 = !t6;
        if ((m == MW || m == ME || m == MS) && msk[sec(rd_addr)]) t2 = !t2;
      end
      case (m)
        MR: if (hp) begin m = MP; cnt = 0; stall = (cmd_data & ~cell_old) != 0; p7 = cmd_data[7]; end
            else if (hs) begin m = MW; cnt = 0; msk = 4'b1 << sec(cmd_addr); end
            else if (hc) begin m = ME; ecnt = 0; msk = 4'hF; end
        MP, MSP: if (stall && cnt == PL - 1) m = MF;
                 else if (!stall && cnt == PC - 1) begin
                   if (m == MP) begin m = MR; msk = 0; end else m = MS;
                 end else cnt++;
        MW: if (hx) begin m = MR; msk = 0; end
            else if (hs) begin msk[sec(cmd_addr)] = 1; cnt = 0; end
            else if (cnt == WC - 1) begin m = ME; ecnt = 0; end
            else cnt++;
        ME: if (ecnt == EC - 1) begin m = MR; msk = 0; end
            else begin ecnt++; if (hu) m = MS; end
        MS: if (hp) begin m = MSP; cnt = 0; stall = (cmd_data & ~cell_old) != 0; p7 = cmd_data[7]; end
            else if (hr) m = ME;
        MF: if (hx) begin m = MR; msk = 0; end
        default: ;
      endcase
    end
  end

  function automatic logic [7:0] exp_dq();
    case (m)
      MP, MSP: return {!p7, t6, 1'b0, 1'b0, 1'b0, t2, 2'b00};
      MW:      return {1'b0, t6, 1'b0, 1'b0, 1'b0, t2, 2'b00};
      ME:      return {1'b0, t6, 1'b0, 1'b0, 1'b1, t2, 2'b00};
      MS:      return msk[sec(rd_addr)] ? {1'b1, t6, 1'b0, 1'b0, 1'b0, t2, 2'b00} : arr_data;
      MF:      return {!p7, t6, 1'b1, 1'b0, 1'b0, t2, 2'b00};
      default: return arr_data;
    endcase
  endfunction

  function automatic string mtag();
    case (m)
      MP: return "R2"; MW: return "R6"; ME: return "R7"; MS: return "R9";
      MSP: return "R10"; MF: return "R5"; default: return "R1";
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive_idle();
    cmd_valid = 0; cmd_op = 0; cmd_addr = 0; cmd_data = 0; cell_old = 0;
    rd_stb = 0; rd_addr = 0;
  endtask

  task automatic look();
    #1;
    chk(32'(dq), 32'(exp_dq()), mtag());
    chk(32'(ready), 32'(m == MR || m == MS), mtag());
  endtask

  task automatic fin();
    @(posedge clk); @(negedge clk); drive_idle();
  endtask

  task automatic issue(input int op, input logic [11:0] a, input logic [7:0] d, input logic [7:0] o);
    cmd_valid = 1; cmd_op = 3'(op); cmd_addr = a; cmd_data = d; cell_old = o;
    look(); fin();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin look(); fin(); end
  endtask

  logic [7:0] sv;

  task automatic rd_pair(input logic [11:0] a, input int bitn, input logic expect_flip, input string tag);
    rd_stb = 1; rd_addr = a; look(); sv = dq; fin();
    rd_stb = 1; rd_addr = a; look();
    chk(32'(dq[bitn]), 32'(expect_flip ? !sv[bitn] : sv[bitn]), tag);
    fin();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    drive_idle(); arr_data = 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1;
    look(); chk(32'(dq), 32'h5A, "R1"); chk(32'(ready), 1, "R1"); fin();

    // R2: normal program, R3: polling bit
    issue(0, 12'h123, 8'h3C, 8'hFF);
    for (int i = 0; i < PC; i++) begin
      rd_stb = (i % 2 == 0); look();
      if (i == 0) begin chk(32'(dq[7]), 1, "R2"); chk(32'(ready), 0, "R2"); end
      fin();
    end
    look(); chk(32'(ready), 1, "R2"); fin();

    // R4/R5: stalled program fails, then holds
    issue(0, 12'h010, 8'hF0, 8'h0F);
    rd_pair(12'h010, 6, 1, "R3");
    rd_stb = 0; look(); sv = dq; fin();
    look(); chk(32'(dq[6]), 32'(sv[6]), "R3"); fin();
    for (int i = 4; i < PL; i++) begin
      look(); if (i == PL - 1) chk(32'(dq[5]), 0, "R4"); fin();
    end
    look(); chk(32'(dq[5]), 1, "R4"); fin();
    issue(1, 12'h400, 8'h00, 8'h00);
    look(); chk(32'(dq[5]), 1, "R5"); chk(32'(ready), 0, "R5"); fin();
    issue(5, 12'h000, 8'h00, 8'h00);
    look(); chk(32'(ready), 1, "R5"); fin();

    // R6: window, restart, reset abandons
    issue(1, 12'h400, 8'h00, 8'h00);
    idle(3);
    issue(5, 12'h000, 8'h00, 8'h00);
    look(); chk(32'(ready), 1, "R6"); fin();
    arr_data = 8'hC3;
    issue(1, 12'h400, 8'h00, 8'h00);
    idle(10);
    issue(1, 12'hC00, 8'h00, 8'h00);
    idle(WC - 1);
    look(); chk(32'(dq[3]), 0, "R6"); fin();
    look(); chk(32'(dq[3]), 1, "R7"); chk(32'(dq[7]), 0, "R7"); fin();

    // R11: sector-selective bit; R8: reset ignored
    rd_pair(12'h800, 2, 0, "R11");
    rd_pair(12'h455, 2, 1, "R11");
    issue(5, 12'h000, 8'h00, 8'h00);
    look(); chk(32'(dq[3]), 1, "R8"); chk(32'(ready), 0, "R8"); fin();
    issue(0, 12'h000, 8'h00, 8'hFF);
    look(); chk(32'(dq[3]), 1, "R8"); fin();

    // R9: suspend reads
    issue(3, 12'h000, 8'h00, 8'h00);
    rd_pair(12'hC10, 2, 1, "R11");
    rd_pair(12'hC10, 6, 0, "R9");
    rd_stb = 1; rd_addr = 12'hC10; look(); chk(32'(dq[7]), 1, "R9"); chk(32'(ready), 1, "R9"); fin();
    rd_stb = 1; rd_addr = 12'h020; look(); chk(32'(dq), 32'hC3, "R9"); fin();

    // R10: program in suspend, then resume to completion
    issue(0, 12'h020, 8'h00, 8'hFF);
    look(); chk(32'(ready), 0, "R10"); chk(32'(dq[7]), 1, "R10"); fin();
    idle(PC - 1);
    look(); chk(32'(ready), 1, "R10"); fin();
    issue(4, 12'h000, 8'h00, 8'h00);
    look(); chk(32'(dq[3]), 1, "R10"); fin();
    for (int g = 0; g < 200 && !ready; g++) begin look(); fin(); end
    look(); chk(32'(ready), 1, "R10"); chk(32'(dq), 32'hC3, "R7"); fin();

    // R7: chip erase skips the window
    issue(2, 12'h000, 8'h00, 8'h00);
    look(); chk(32'(dq[3]), 1, "R7"); fin();
    rd_pair(12'h800, 2, 1, "R11");
    idle(EC);
    look(); chk(32'(ready), 1, "R7"); fin();

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule